// File: doc/BRIEF.md
# Processor Hot-Plug Presence Register Block

This block keeps one presence bit for every processor that can be addressed by its interrupt-controller ID, and signals the system controller when processors come and go. System firmware reads the presence bits as a read-only window of bytes on a byte-wide I/O bus. The platform reports each processor add or remove on a separate event port, which carries the processor ID and a plug or unplug strobe.

Every accepted event sets the processor hot-plug bit in a general-purpose event status byte. A PCI hot-plug strobe sets a neighbouring status bit. The status bits are write-one-to-clear. An enable byte masks them, and the masked result is combined with an external power-management interrupt condition to drive a level interrupt. After reset the presence bits are loaded from a preload vector that describes the processors already fitted.

Top module: `cpu_hotplug_notifier`

## Requirements
- R1: While reset is asserted, `bus_rvalid_o`, `bus_rdata_o`, `id_err_o` and `irq_o` are 0 (with `pm_irq_i` low), and the event status and enable bytes are 0. The first clock edge after reset release copies `preload_i` into the presence map. Events presented in that first cycle are dropped.
- R2: A read strobe (`bus_req_i`=1, `bus_we_i`=0) is answered one cycle later with `bus_rvalid_o`=1 and `bus_rdata_o`. A read of address 0xAF00+k (k in 0..31) returns presence bits 8k+7..8k, so processor n sits in byte n/8 at bit n%8. A read made in the same cycle as an event returns the map as it was before that event.
- R3: A plug strobe with ID n (n<256) sets presence bit n, and an unplug strobe clears it, from the next clock edge on. Plug and unplug are never asserted together.
- R4: Bus writes to 0xAF00..0xAF1F leave the presence map unchanged.
- R5: Every accepted plug or unplug event sets status bit 2 of the event status byte, which is read at 0xAFE0.
- R6: Writing the event status byte at 0xAFE0 clears each bit that is written as 1. The enable byte at 0xAFE2 is read/write. 0xAFE1 and 0xAFE3 read as 0 and ignore writes. When a set and a clear hit the same status bit in one cycle, the bit ends up set.
- R7: A `pci_evt_i` strobe sets status bit 1.
- R8: `irq_o` is 1 exactly when (status AND enable AND 0x06) is non-zero or `pm_irq_i` is 1. It follows register changes without any further delay.
- R9: An event with an ID of 256 or more changes neither the map nor the status byte. It raises `id_err_o` for the one cycle after the strobe.
- R10: A read of any address outside the presence window and the event status and enable bytes returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe, one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Byte I/O address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| preload_i | input | 256 | Presence bits loaded after reset |
| plug_i | input | 1 | Processor added strobe |
| unplug_i | input | 1 | Processor removed strobe |
| cpu_id_i | input | 9 | Interrupt-controller ID of the event |
| pci_evt_i | input | 1 | PCI hot-plug event strobe |
| pm_irq_i | input | 1 | Combined power-management interrupt condition |
| irq_o | output | 1 | Level system control interrupt |
| id_err_o | output | 1 | Out-of-range event ID pulse |

## Verification
A processor event and a firmware write-one-to-clear of the status byte can land in the same cycle. So can a processor event and a bus read of the map byte that the event changes. The bench drives the event and the bus access in a single cycle. It then judges the first case by reading the status byte back and by watching the interrupt level: bit 2 must still be set. It judges the second case by checking that the read returns the pre-event byte and that a later read shows the update.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int GPE_PCI_BIT = 1;
  localparam int GPE_CPU_BIT = 2;
  localparam logic [7:0] GPE_IRQ_MASK = 8'h06;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MAP,
    SEL_GPE
  } hp_sel_e;
endpackage

// File: rtl/hp_addr_dec.sv
module hp_addr_dec
  import hp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MAP_BYTES = 32,
  parameter int GPE_LEN = 4,
  parameter logic [ADDR_W-1:0] MAP_BASE = 16'hAF00,
  parameter logic [ADDR_W-1:0] GPE_BASE = 16'hAFE0,
  localparam int MOFF_W = $clog2(MAP_BYTES),
  localparam int GOFF_W = $clog2(GPE_LEN)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hp_sel_e           sel_o,
  output logic [MOFF_W-1:0] map_off_o,
  output logic [GOFF_W-1:0] gpe_off_o
);
  // Both windows are naturally aligned to their size.
  logic in_map, in_gpe;
  assign in_map    = addr_i[ADDR_W-1:MOFF_W] == MAP_BASE[ADDR_W-1:MOFF_W];
  assign in_gpe    = addr_i[ADDR_W-1:GOFF_W] == GPE_BASE[ADDR_W-1:GOFF_W];
  assign map_off_o = addr_i[MOFF_W-1:0];
  assign gpe_off_o = addr_i[GOFF_W-1:0];

  always_comb begin
    if (in_map)      sel_o = SEL_MAP;
    else if (in_gpe) sel_o = SEL_GPE;
    else             sel_o = SEL_NONE;
  end
endmodule

// File: rtl/hp_presence_map.sv
module hp_presence_map #(
  parameter int NUM_CPU = 256,
  parameter int ID_W = 9,
  localparam int IDX_W = $clog2(NUM_CPU),
  localparam int OFF_W = $clog2(NUM_CPU / 8)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CPU-1:0] preload_i,
  input  logic               plug_i,
  input  logic               unplug_i,
  input  logic [ID_W-1:0]    id_i,
  input  logic [OFF_W-1:0]   rd_off_i,
  output logic [7:0]         rd_byte_o,
  output logic               evt_ok_o,
  output logic               err_o
);
  logic [NUM_CPU-1:0] map_q;
  logic               loaded_q;
  logic               id_ok, any_evt;
  logic [IDX_W-1:0]   idx;

  assign id_ok    = {1'b0, id_i} < (ID_W + 1)'(NUM_CPU);
  assign any_evt  = plug_i | unplug_i;
  assign idx      = id_i[IDX_W-1:0];
  assign evt_ok_o = loaded_q & any_evt & id_ok;
  assign rd_byte_o = map_q[{rd_off_i, 3'b000} +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      loaded_q <= 1'b1;
      err_o    <= any_evt & ~id_ok;
    end
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              map_q[i] <= 1'b0;
      else if (!loaded_q)                       map_q[i] <= preload_i[i];
      else if (evt_ok_o && idx == IDX_W'(i))    map_q[i] <= plug_i;
    end
  end

  a_r3_plug_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && plug_i && id_ok) |=> map_q[$past(idx)]);
  a_r3_unplug_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && unplug_i && id_ok) |=> !map_q[$past(idx)]);
  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(plug_i && unplug_i));
  a_r9_bad_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && any_evt && !id_ok) |=> (err_o && $stable(map_q)));
endmodule

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs
  import hp_pkg::*;
#(
  parameter int GPE_LEN = 4,
  localparam int GOFF_W = $clog2(GPE_LEN),
  localparam logic [GOFF_W-1:0] STS_OFF = '0,
  localparam logic [GOFF_W-1:0] EN_OFF = GOFF_W'(GPE_LEN / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [GOFF_W-1:0] off_i,
  input  logic [7:0]        wdata_i,
  input  logic              cpu_evt_i,
  input  logic              pci_evt_i,
  input  logic              pm_irq_i,
  output logic [7:0]        rd_byte_o,
  output logic              irq_o
);
  logic [7:0] sts_q, en_q, clr, set;

  assign clr = (wr_i && off_i == STS_OFF) ? wdata_i : 8'h00;

  always_comb begin
    set = 8'h00;
    set[GPE_CPU_BIT] = cpu_evt_i;
    set[GPE_PCI_BIT] = pci_evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 8'h00;
      en_q  <= 8'h00;
    end else begin
      sts_q <= (sts_q & ~clr) | set;  // set beats clear
      if (wr_i && off_i == EN_OFF) en_q <= wdata_i;
    end
  end

  always_comb begin
    if (off_i == STS_OFF)     rd_byte_o = sts_q;
    else if (off_i == EN_OFF) rd_byte_o = en_q;
    else                      rd_byte_o = 8'h00;
  end

  assign irq_o = (|(sts_q & en_q & GPE_IRQ_MASK)) | pm_irq_i;

  a_r5_cpu_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_evt_i |=> sts_q[GPE_CPU_BIT]);
  a_r7_pci_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_evt_i |=> sts_q[GPE_PCI_BIT]);
  a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == STS_OFF && wdata_i[GPE_CPU_BIT] && !cpu_evt_i) |=> !sts_q[GPE_CPU_BIT]);
  a_r8_pm_forces_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_irq_i |-> irq_o);
endmodule

// File: rtl/cpu_hotplug_notifier.sv
module cpu_hotplug_notifier
  import hp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CPU = 256,
  parameter int ID_W = 9,
  parameter int GPE_LEN = 4,
  parameter logic [ADDR_W-1:0] MAP_BASE = 16'hAF00,
  parameter logic [ADDR_W-1:0] GPE_BASE = 16'hAFE0,
  localparam int MAP_BYTES = NUM_CPU / 8,
  localparam int MOFF_W = $clog2(MAP_BYTES),
  localparam int GOFF_W = $clog2(GPE_LEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  output logic               bus_rvalid_o,
  input  logic [NUM_CPU-1:0] preload_i,
  input  logic               plug_i,
  input  logic               unplug_i,
  input  logic [ID_W-1:0]    cpu_id_i,
  input  logic               pci_evt_i,
  input  logic               pm_irq_i,
  output logic               irq_o,
  output logic               id_err_o
);
  hp_sel_e           sel;
  logic [MOFF_W-1:0] map_off;
  logic [GOFF_W-1:0] gpe_off;
  logic [7:0]        map_byte, gpe_byte;
  logic              cpu_evt, gpe_wr, rd_req;

  hp_addr_dec #(
    .ADDR_W(ADDR_W), .MAP_BYTES(MAP_BYTES), .GPE_LEN(GPE_LEN),
    .MAP_BASE(MAP_BASE), .GPE_BASE(GPE_BASE)
  ) i_dec (
    .addr_i(bus_addr_i), .sel_o(sel), .map_off_o(map_off), .gpe_off_o(gpe_off)
  );

  hp_presence_map #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) i_map (
    .clk_i, .rst_ni, .preload_i, .plug_i, .unplug_i,
    .id_i(cpu_id_i), .rd_off_i(map_off), .rd_byte_o(map_byte),
    .evt_ok_o(cpu_evt), .err_o(id_err_o)
  );

  assign gpe_wr = bus_req_i & bus_we_i & (sel == SEL_GPE);
  assign rd_req = bus_req_i & ~bus_we_i;

  hp_gpe_regs #(.GPE_LEN(GPE_LEN)) i_gpe (
    .clk_i, .rst_ni, .wr_i(gpe_wr), .off_i(gpe_off), .wdata_i(bus_wdata_i),
    .cpu_evt_i(cpu_evt), .pci_evt_i, .pm_irq_i,
    .rd_byte_o(gpe_byte), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= 8'h00;
    end else begin
      bus_rvalid_o <= rd_req;
      if (rd_req) begin
        unique case (sel)
          SEL_MAP: bus_rdata_o <= map_byte;
          SEL_GPE: bus_rdata_o <= gpe_byte;
          default: bus_rdata_o <= 8'h00;
        endcase
      end
    end
  end

  a_r2_read_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> bus_rvalid_o);
  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !bus_rvalid_o);
endmodule

// File: tb/test_cpu_hotplug_notifier.sv
module test_cpu_hotplug_notifier;
  localparam time HALF = 4ns;  // 125 MHz

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [15:0]  bus_addr_i = '0;
  logic [7:0]   bus_wdata_i = '0;
  logic [7:0]   bus_rdata_o;
  logic         bus_rvalid_o;
  logic [255:0] preload_i;
  logic         plug_i = 1'b0, unplug_i = 1'b0, pci_evt_i = 1'b0, pm_irq_i = 1'b0;
  logic [8:0]   cpu_id_i = '0;
  logic         irq_o, id_err_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [255:0] m_map = '0;
  logic [7:0]   m_sts = '0, m_en = '0;
  logic         m_err = 1'b0;
  logic [7:0]   exp_q[$];
  string        tag_q[$];

  always #HALF clk_i = ~clk_i;

  cpu_hotplug_notifier i_cpu_hotplug_notifier (.*);

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_exp(input logic [15:0] a);
    if (a[15:5] == 11'(16'hAF00 >> 5)) return m_map[{a[4:0], 3'b000} +: 8];
    if (a == 16'hAFE0) return m_sts;
    if (a == 16'hAFE2) return m_en;
    return 8'h00;
  endfunction

  // Scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && bus_rvalid_o) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected rvalid", bus_rdata_o, 8'h00);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata_o === e, t, bus_rdata_o, e);
      end
    end
  end

  // Driver: one bus access and/or event for one cycle, model updated per requirements
  task automatic step(input logic req, input logic we, input logic [15:0] addr,
                      input logic [7:0] wd, input logic pl, input logic up,
                      input logic [8:0] id, input logic pci, input string tag);
    @(posedge clk_i); #1;
    if (req && !we) begin exp_q.push_back(f_exp(addr)); tag_q.push_back(tag); end
    bus_req_i = req; bus_we_i = we; bus_addr_i = addr; bus_wdata_i = wd;
    plug_i = pl; unplug_i = up; cpu_id_i = id; pci_evt_i = pci;
    m_err = (pl | up) && id >= 9'd256;
    if (req && we && addr == 16'hAFE0) m_sts = m_sts & ~wd;
    if (req && we && addr == 16'hAFE2) m_en = wd;
    if ((pl | up) && id < 9'd256) begin m_map[id[7:0]] = pl; m_sts[2] = 1'b1; end
    if (pci) m_sts[1] = 1'b1;
    @(posedge clk_i); #1;
    bus_req_i = 0; bus_we_i = 0; plug_i = 0; unplug_i = 0; pci_evt_i = 0;
    @(negedge clk_i);
    chk(irq_o === (((m_sts & m_en & 8'h06) != 0) || pm_irq_i), {"R8 irq after ", tag},
        {7'd0, irq_o}, 8'h00);
    chk(id_err_o === m_err, {"R9 id_err after ", tag}, {7'd0, id_err_o}, {7'd0, m_err});
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(1, 0, a, 8'h00, 0, 0, 9'd0, 0, tag);
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(1, 1, a, d, 0, 0, 9'd0, 0, tag);
  endtask
  task automatic ev(input logic pl, input logic [8:0] id, input string tag);
    step(0, 0, 16'h0000, 8'h00, pl, ~pl, id, 0, tag);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    preload_i = '0;
    preload_i[0] = 1; preload_i[1] = 1; preload_i[3] = 1;
    preload_i[100] = 1; preload_i[129] = 1; preload_i[255] = 1;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(bus_rvalid_o === 1'b0, "R1 rvalid in reset", {7'd0, bus_rvalid_o}, 8'h00);
    chk(bus_rdata_o === 8'h00, "R1 rdata in reset", bus_rdata_o, 8'h00);
    chk(irq_o === 1'b0, "R1 irq in reset", {7'd0, irq_o}, 8'h00);
    chk(id_err_o === 1'b0, "R1 id_err in reset", {7'd0, id_err_o}, 8'h00);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(posedge clk_i);  // preload edge
    m_map = preload_i;

    // R1/R2: preload visible, byte/bit placement
    for (int k = 0; k < 32; k++) rd(16'hAF00 + 16'(k), "R1 R2 preload map byte");
    rd(16'hAFE0, "R1 status zero");
    rd(16'hAFE2, "R1 enable zero");

    // R3/R5: plug and unplug
    ev(1, 9'd5,   "R3 plug 5");
    ev(1, 9'd200, "R3 plug 200");
    ev(0, 9'd0,   "R3 unplug 0");
    ev(0, 9'd255, "R3 unplug 255");
    ev(0, 9'd100, "R3 unplug 100");
    ev(1, 9'd254, "R3 plug 254");
    rd(16'hAF00, "R3 byte 0");
    rd(16'hAF0C, "R3 byte 12");
    rd(16'hAF19, "R3 byte 25");
    rd(16'hAF1F, "R3 byte 31");
    rd(16'hAFE0, "R5 status bit2 set");

    // R4: writes to map ignored
    wr(16'hAF00, 8'hFF, "R4 write byte 0");
    wr(16'hAF1F, 8'h00, "R4 write byte 31");
    wr(16'hAF10, 8'hA5, "R4 write byte 16");
    rd(16'hAF00, "R4 byte 0 unchanged");
    rd(16'hAF1F, "R4 byte 31 unchanged");
    rd(16'hAF10, "R4 byte 16 unchanged");

    // R9: out-of-range IDs
    ev(1, 9'd256, "R9 plug 256");
    ev(0, 9'd300, "R9 unplug 300");
    ev(1, 9'd511, "R9 plug 511");
    rd(16'hAF00, "R9 byte 0 unchanged");
    rd(16'hAF05, "R9 byte 5 unchanged");

    // R6/R8: enable, W1C, masking
    wr(16'hAFE2, 8'h04, "R6 enable cpu");
    rd(16'hAFE2, "R6 enable readback");
    wr(16'hAFE0, 8'h04, "R6 w1c bit2");
    rd(16'hAFE0, "R6 status cleared");
    ev(1, 9'd9, "R9 unused id err low");
    wr(16'hAFE0, 8'h00, "R6 w1c zero no effect");
    rd(16'hAFE0, "R6 status still set");
    wr(16'hAFE0, 8'hFF, "R6 w1c all");

    // R7/R8: PCI bit masked then enabled
    step(0, 0, 16'h0, 8'h00, 0, 0, 9'd0, 1, "R7 pci event masked");
    rd(16'hAFE0, "R7 status bit1");
    wr(16'hAFE2, 8'h06, "R8 enable pci");
    wr(16'hAFE0, 8'h02, "R8 clear pci");
    wr(16'hAFE2, 8'hF9, "R8 enable unused bits only");
    ev(1, 9'd12, "R8 masked cpu event");

    // R8: pm input drives irq directly
    @(posedge clk_i); #1 pm_irq_i = 1'b1;
    @(negedge clk_i);
    chk(irq_o === 1'b1, "R8 pm_irq forces irq", {7'd0, irq_o}, 8'h01);
    @(posedge clk_i); #1 pm_irq_i = 1'b0;
    @(negedge clk_i);
    chk(irq_o === 1'b0, "R8 pm_irq released", {7'd0, irq_o}, 8'h00);

    // R6: event and W1C in the same cycle, set wins
    wr(16'hAFE2, 8'h04, "R6 enable cpu again");
    step(1, 1, 16'hAFE0, 8'h04, 1, 0, 9'd7, 0, "R6 w1c with event");
    rd(16'hAFE0, "R6 set beats clear");

    // R2: read and event in the same cycle return the old byte
    step(1, 0, 16'hAF00, 8'h00, 0, 1, 9'd3, 0, "R2 read during unplug 3");
    rd(16'hAF00, "R2 byte 0 after unplug 3");
    step(1, 0, 16'hAF0F, 8'h00, 1, 0, 9'd120, 0, "R2 read during plug 120");
    rd(16'hAF0F, "R2 byte 15 after plug 120");

    // R10/R6: unmapped addresses
    wr(16'hAFE3, 8'hFF, "R6 write reserved");
    wr(16'hAFE1, 8'hFF, "R6 write reserved 1");
    rd(16'hAFE1, "R6 reserved 1 zero");
    rd(16'hAFE3, "R6 reserved 3 zero");
    rd(16'hAFE2, "R6 enable kept");
    rd(16'hAF20, "R10 past map");
    rd(16'hAEFF, "R10 before map");
    rd(16'h0000, "R10 address 0");
    rd(16'hAFE4, "R10 past gpe");

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 outstanding reads", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule